// File: doc/BRIEF.md
# Triggered Circular Trace Capture Buffer

The block records a stream of trace words into an internal RAM that is written as a ring. Capture runs while the enable bit is set and a trigger countdown register holds a nonzero value. The countdown stays put until the trigger input fires. From then on it loses one for every word stored, and the word that arrives with the trigger counts too. When it reaches zero, storage stops and the acquisition-complete output rises so that it can raise an interrupt.

The count sets how much history sits on each side of the event. Half the RAM depth keeps about equal amounts before and after the trigger. A small count keeps mostly earlier trace. Once capture is switched off, software drains the ring one word at a time through the data register, and each read advances the read pointer.

Registers are reached through a simple select/strobe bus with eight 32-bit locations. A read strobe returns its value on the cycle after the strobe.

Top module: `trace_capture_buf`

## Requirements
- R1: After reset, `acq_done_o` is 0, and the control, status, read pointer, write pointer and trigger count registers all read 0.
- R2: A word on `trc_data_i` is stored, at the write pointer, in each cycle where `trc_valid_i` is high, control bit 0 is 1, and the trigger count is nonzero. The write pointer then advances by one and wraps from DEPTH-1 to 0. With a count of zero, nothing is stored.
- R3: The trigger count does not change before the trigger. It drops by one for each word stored in the cycle where `trig_i` is high and in every later storing cycle.
- R4: `acq_done_o` is high exactly when a trigger has been seen and the count is zero. Status bit 0 reports that a trigger was seen, and bit 1 reports that acquisition is complete.
- R5: Status bit 2 becomes 1 when the write pointer wraps from DEPTH-1 to 0, and stays set.
- R6: With capture off, a read of the data register returns the RAM word at the read pointer on the next cycle. The read pointer then advances by one and wraps at DEPTH.
- R7: With capture on, a read of the data register returns 0 and leaves the read pointer unchanged.
- R8: With capture on, writes to the read pointer, write pointer and trigger count registers have no effect.
- R9: The depth register reads DEPTH and the width register reads WIDTH. Writes to either of them have no effect.
- R10: A write that sets control bit 0 while it is 0 clears all three status bits.
- R11: Register select codes are: 0 control, 1 status, 2 read pointer, 3 write pointer, 4 trigger count, 5 RAM data, 6 depth, 7 width. Reads return data one cycle after the `bus_rd_i` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trc_valid_i | input | 1 | Trace word strobe |
| trc_data_i | input | WIDTH | Trace word |
| trig_i | input | 1 | Trigger event |
| bus_sel_i | input | 3 | Register select |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data, valid the cycle after a read strobe |
| acq_done_o | output | 1 | Acquisition complete |

## Verification
The hardest case to reach is a trigger late enough that the ring has already wrapped several times before the countdown ends. The surviving contents are then the last DEPTH words, and they begin part-way through the RAM. The stimulus table places the trigger at the first word, mid-stream, late in the stream, and at the exact point where storage ends on the wrap boundary. For each case the bench sets the read pointer to the final write pointer and drains the whole ring, comparing it with the expected word sequence. Directed tests hold capture on while poking the protected registers, and run a stream with no trigger to show that the count is frozen.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [2:0] {
    REG_CTRL  = 3'd0,
    REG_STAT  = 3'd1,
    REG_RDPTR = 3'd2,
    REG_WRPTR = 3'd3,
    REG_TCNT  = 3'd4,
    REG_DATA  = 3'd5,
    REG_DEPTH = 3'd6,
    REG_WIDTH = 3'd7
  } tcb_reg_e;
endpackage

// File: rtl/tcb_ram.sv
module tcb_ram #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/tcb_capture.sv
module tcb_capture #(
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int CW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic          cap_start,
  input  logic          trc_valid,
  input  logic          trig_in,
  input  logic          ptr_load,
  input  logic          cnt_load,
  input  logic [CW-1:0] load_val,
  output logic          store,
  output logic [AW-1:0] wr_ptr,
  output logic [CW-1:0] tcnt,
  output logic          trig_seen,
  output logic          wrapped,
  output logic          acq_done
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [CW-1:0] tcnt_q, tcnt_d;
  logic          trig_q, trig_d;
  logic          wrap_q, wrap_d;

  always_comb begin
    store    = cap_en && trc_valid && (tcnt_q != '0);
    wr_ptr_d = wr_ptr_q;
    tcnt_d   = tcnt_q;
    trig_d   = trig_q;
    wrap_d   = wrap_q;
    if (cap_start) begin
      trig_d = 1'b0;
      wrap_d = 1'b0;
    end else if (cap_en && trig_in) begin
      trig_d = 1'b1;
    end
    if (ptr_load) begin
      wr_ptr_d = load_val[AW-1:0];
    end else if (store) begin
      wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (wr_ptr_q == LAST) wrap_d = 1'b1;
    end
    if (cnt_load) begin
      tcnt_d = load_val;
    end else if (store && (trig_q || trig_in)) begin
      tcnt_d = tcnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      tcnt_q   <= '0;
      trig_q   <= 1'b0;
      wrap_q   <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      tcnt_q   <= tcnt_d;
      trig_q   <= trig_d;
      wrap_q   <= wrap_d;
    end
  end

  assign wr_ptr    = wr_ptr_q;
  assign tcnt      = tcnt_q;
  assign trig_seen = trig_q;
  assign wrapped   = wrap_q;
  assign acq_done  = trig_q && (tcnt_q == '0);
endmodule

// File: rtl/tcb_readout.sv
module tcb_readout
  import tcb_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_load,
  input  logic [AW-1:0]    load_val,
  input  logic             ram_rd,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] reg_val,
  input  logic [WIDTH-1:0] ram_q,
  output logic [AW-1:0]    rd_ptr,
  output logic [BUS_W-1:0] rdata
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0]    rd_ptr_q, rd_ptr_d;
  logic [BUS_W-1:0] rval_q, rval_d;
  logic             from_ram_q, from_ram_d;

  always_comb begin
    rd_ptr_d   = rd_ptr_q;
    rval_d     = rval_q;
    from_ram_d = from_ram_q;
    if (ptr_load) begin
      rd_ptr_d = load_val;
    end else if (ram_rd) begin
      rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    end
    if (bus_rd) begin
      from_ram_d = ram_rd;
      rval_d     = reg_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr_q   <= '0;
      rval_q     <= '0;
      from_ram_q <= 1'b0;
    end else begin
      rd_ptr_q   <= rd_ptr_d;
      rval_q     <= rval_d;
      from_ram_q <= from_ram_d;
    end
  end

  assign rd_ptr = rd_ptr_q;
  assign rdata  = from_ram_q ? BUS_W'(ram_q) : rval_q;
endmodule

// File: rtl/trace_capture_buf.sv
module trace_capture_buf
  import tcb_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trc_valid_i,
  input  logic [WIDTH-1:0] trc_data_i,
  input  logic             trig_i,
  input  logic [2:0]       bus_sel_i,
  input  logic             bus_wr_i,
  input  logic             bus_rd_i,
  input  logic [31:0]      bus_wdata_i,
  output logic [31:0]      bus_rdata_o,
  output logic             acq_done_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = BUS_W;

  tcb_reg_e         sel;
  logic             cap_en_q, cap_en_d;
  logic             cap_start;
  logic             wptr_load, rptr_load, cnt_load, ram_rd;
  logic             store, trig_seen, wrapped, acq_done;
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    tcnt;
  logic [WIDTH-1:0] ram_q;
  logic [BUS_W-1:0] reg_val;

  assign sel = tcb_reg_e'(bus_sel_i);

  always_comb begin
    cap_en_d  = cap_en_q;
    cap_start = 1'b0;
    if (bus_wr_i && sel == REG_CTRL) begin
      cap_en_d  = bus_wdata_i[0];
      cap_start = bus_wdata_i[0] && !cap_en_q;
    end
    wptr_load = bus_wr_i && sel == REG_WRPTR && !cap_en_q;
    rptr_load = bus_wr_i && sel == REG_RDPTR && !cap_en_q;
    cnt_load  = bus_wr_i && sel == REG_TCNT  && !cap_en_q;
    ram_rd    = bus_rd_i && sel == REG_DATA  && !cap_en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_en_q <= 1'b0;
    else        cap_en_q <= cap_en_d;
  end

  always_comb begin
    unique case (sel)
      REG_CTRL:  reg_val = BUS_W'(cap_en_q);
      REG_STAT:  reg_val = BUS_W'({wrapped, acq_done, trig_seen});
      REG_RDPTR: reg_val = BUS_W'(rd_ptr);
      REG_WRPTR: reg_val = BUS_W'(wr_ptr);
      REG_TCNT:  reg_val = tcnt;
      REG_DEPTH: reg_val = BUS_W'(DEPTH);
      REG_WIDTH: reg_val = BUS_W'(WIDTH);
      default:   reg_val = '0;
    endcase
  end

  tcb_capture #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en_q),
    .cap_start (cap_start),
    .trc_valid (trc_valid_i),
    .trig_in   (trig_i),
    .ptr_load  (wptr_load),
    .cnt_load  (cnt_load),
    .load_val  (bus_wdata_i),
    .store     (store),
    .wr_ptr    (wr_ptr),
    .tcnt      (tcnt),
    .trig_seen (trig_seen),
    .wrapped   (wrapped),
    .acq_done  (acq_done)
  );

  tcb_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (store),
    .waddr (wr_ptr),
    .wdata (trc_data_i),
    .re    (ram_rd),
    .raddr (rd_ptr),
    .rdata (ram_q)
  );

  tcb_readout #(.DEPTH(DEPTH), .AW(AW), .WIDTH(WIDTH)) u_readout (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptr_load (rptr_load),
    .load_val (bus_wdata_i[AW-1:0]),
    .ram_rd   (ram_rd),
    .bus_rd   (bus_rd_i),
    .reg_val  (reg_val),
    .ram_q    (ram_q),
    .rd_ptr   (rd_ptr),
    .rdata    (bus_rdata_o)
  );

  assign acq_done_o = acq_done;
endmodule

// File: rtl/tcb_checker.sv
module tcb_checker #(
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int CW    = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cap_en,
  input logic          store,
  input logic          trig_in,
  input logic          trig_seen,
  input logic          acq_done,
  input logic [AW-1:0] wr_ptr,
  input logic [AW-1:0] rd_ptr,
  input logic [CW-1:0] tcnt
);
  AST_WRPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> wr_ptr == (($past(wr_ptr) == AW'(DEPTH - 1)) ? '0 : $past(wr_ptr) + 1'b1)); // R2
  AST_CNT_FROZEN_PRE_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !trig_seen && !trig_in) |=> $stable(tcnt)); // R3
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_done && cap_en) |=> acq_done); // R4
  AST_NO_STORE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_done && cap_en) |=> $stable(wr_ptr)); // R2
  AST_RDPTR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> $stable(rd_ptr)); // R8
endmodule

bind trace_capture_buf tcb_checker #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cap_en    (cap_en_q),
  .store     (store),
  .trig_in   (trig_i),
  .trig_seen (trig_seen),
  .acq_done  (acq_done),
  .wr_ptr    (wr_ptr),
  .rd_ptr    (rd_ptr),
  .tcnt      (tcnt)
);

// File: tb/test_trace_capture_buf.sv
module test_trace_capture_buf;
  localparam int D = 16;
  localparam int W = 16;

  typedef struct packed {
    int trig_at;
    int cnt;
    int n;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{trig_at: 0,  cnt: 8, n: 30},
    '{trig_at: 20, cnt: 8, n: 60},
    '{trig_at: 40, cnt: 2, n: 60},
    '{trig_at: 8,  cnt: 8, n: 40}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          trc_valid_i = 1'b0;
  logic [W-1:0]  trc_data_i = '0;
  logic          trig_i = 1'b0;
  logic [2:0]    bus_sel_i = '0;
  logic          bus_wr_i = 1'b0;
  logic          bus_rd_i = 1'b0;
  logic [31:0]   bus_wdata_i = '0;
  logic [31:0]   bus_rdata_o;
  logic          acq_done_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  trace_capture_buf #(.DEPTH(D), .WIDTH(W)) i_trace_capture_buf (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input int a, input logic [31:0] v);
    bus_sel_i = 3'(a); bus_wdata_i = v; bus_wr_i = 1'b1;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic reg_rd(input int a, output logic [31:0] v);
    bus_sel_i = 3'(a); bus_rd_i = 1'b1;
    @(negedge clk);
    bus_rd_i = 1'b0;
    v = bus_rdata_o;
  endtask

  task automatic push(input int n, input int trig_at, input logic [W-1:0] base);
    for (int i = 0; i < n; i++) begin
      trc_valid_i = 1'b1;
      trc_data_i  = base + W'(i);
      trig_i      = (i == trig_at);
      @(negedge clk);
    end
    trc_valid_i = 1'b0;
    trig_i = 1'b0;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R9 constants, R11 map
    chk("R1 acq_done", 32'(acq_done_o), 0);
    reg_rd(0, v); chk("R1 ctrl", v, 0);
    reg_rd(1, v); chk("R1 status", v, 0);
    reg_rd(2, v); chk("R1 rdptr", v, 0);
    reg_rd(3, v); chk("R1 wrptr", v, 0);
    reg_rd(4, v); chk("R1 tcnt", v, 0);
    reg_rd(6, v); chk("R9 depth", v, D);
    reg_rd(7, v); chk("R11 width", v, W);
    reg_wr(6, 5); reg_wr(7, 3);
    reg_rd(6, v); chk("R9 depth after write", v, D);
    reg_rd(7, v); chk("R9 width after write", v, W);

    // stimulus table: trigger at start, middle, late, and at wrap boundary
    for (int s = 0; s < 4; s++) begin
      int stored, first, cnt, start;
      logic [W-1:0] base;
      base = W'(16'h1000 * (s + 1));
      stored = VEC[s].trig_at + VEC[s].cnt;
      reg_wr(3, 0); reg_wr(2, 0); reg_wr(4, VEC[s].cnt);
      reg_wr(0, 1);
      push(VEC[s].n, VEC[s].trig_at, base);
      chk("R4 acq_done", 32'(acq_done_o), 1);
      reg_rd(1, v); chk("R4 R5 status", v, (stored >= D) ? 7 : 3);
      reg_rd(3, v); chk("R2 wrptr", v, stored % D);
      reg_rd(4, v); chk("R3 tcnt zero", v, 0);
      reg_wr(0, 0);
      start = (stored >= D) ? stored % D : 0;
      first = (stored >= D) ? stored - D : 0;
      cnt   = (stored >= D) ? D : stored;
      reg_wr(2, start);
      for (int k = 0; k < cnt; k++) begin
        reg_rd(5, v);
        chk("R6 ram word", v, 32'(base + W'(first + k)));
      end
      reg_rd(2, v); chk("R6 rdptr advanced", v, (start + cnt) % D);
    end

    // R2 zero count stores nothing
    reg_wr(3, 0); reg_wr(4, 0); reg_wr(2, 3);
    reg_wr(0, 1);
    push(5, 0, 16'h5000);
    reg_rd(3, v); chk("R2 zero count no store", v, 0);

    // R8 / R7 blocked while capture on
    reg_wr(2, 9); reg_rd(2, v); chk("R8 rdptr write ignored", v, 3);
    reg_wr(4, 7); reg_rd(4, v); chk("R8 tcnt write ignored", v, 0);
    reg_wr(3, 6); reg_rd(3, v); chk("R8 wrptr write ignored", v, 0);
    reg_rd(5, v); chk("R7 data read blocked", v, 0);
    reg_rd(2, v); chk("R7 rdptr unchanged", v, 3);

    // R10 re-enable clears flags (trigger was seen above)
    reg_rd(1, v); chk("R10 flags before", v, 3);
    reg_wr(0, 0); reg_wr(0, 1);
    reg_rd(1, v); chk("R10 flags cleared", v, 0);
    chk("R10 acq_done cleared", 32'(acq_done_o), 0);

    // R3 count frozen until trigger
    reg_wr(0, 0); reg_wr(3, 0); reg_wr(4, 4); reg_wr(0, 1);
    push(6, -1, 16'h6000);
    reg_rd(3, v); chk("R3 pre-trigger stores", v, 6);
    reg_rd(4, v); chk("R3 count frozen", v, 4);
    chk("R4 not done", 32'(acq_done_o), 0);
    push(10, 0, 16'h7000);
    reg_rd(3, v); chk("R3 post-trigger stores", v, 10);
    reg_rd(4, v); chk("R3 count reached zero", v, 0);
    chk("R4 done", 32'(acq_done_o), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule